// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block chooses which resident warp issues its next instruction. Each warp shows the block the register indices of its next instruction: two source registers and one destination register, plus a flag that says whether the destination is written. The block keeps a pending bit for every register of every warp. A set bit means a write to that register is still outstanding, for example a long-latency load. A warp may issue only when it is resident, both of its source registers are clear, and its destination register, if it writes one, is clear too.

When more than one warp is eligible, the block grants one of them. The search starts at the warp that follows the last warp that actually issued and wraps around. The granted instruction marks its destination register pending. A writeback port clears the bit when the data comes back. A single grant stands for every lane of the warp. Because each instruction occupies the pipeline for several clocks, grants are at least `ISSUE_GAP` cycles apart. Many resident warps let the block hide long memory latency by switching among whichever warps are ready.

Top module: `wsched_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `grant_valid` is 0. Every pending bit is clear, and the round-robin pointer is set so that warp 0 has first priority.
- R2: A warp whose `warp_valid` bit is 0 is never granted, whatever its register indices are.
- R3: A warp is not granted while either of its source registers is pending. Warp w's source A index sits at bits [w*REG_W +: REG_W] of `src_a_idx`, and the same layout applies to `src_b_idx` and `dst_idx`.
- R4: A warp whose `dst_en` bit is 1 is not granted while its destination register is pending.
- R5: Issuing an instruction whose `dst_en` bit is 1 makes that warp's destination register pending from the next cycle on.
- R6: A writeback (`wb_valid`=1, with `wb_warp` and `wb_reg`) clears that register's pending bit from the next cycle on. If the writeback arrives in the same cycle as an issue that marks the same register, the register ends up clear.
- R7: Among eligible warps, the grant goes to the first one found by searching upward from the warp after the last granted one, wrapping from NUM_WARPS-1 to 0. The pointer moves only when a grant is made.
- R8: If no warp is eligible in a cycle, no grant follows from that cycle.
- R9: After a grant, no further grant is made for the next ISSUE_GAP-1 cycles. A grant lasts exactly one cycle.
- R10: The grant decision uses the inputs and pending state of one cycle and shows up on `grant_valid`/`grant_warp` in the next cycle. `grant_warp` is the binary warp index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_valid | input | NUM_WARPS | Resident flag for each warp |
| src_a_idx | input | NUM_WARPS*REG_W | First source register of each warp's next instruction |
| src_b_idx | input | NUM_WARPS*REG_W | Second source register of each warp's next instruction |
| dst_idx | input | NUM_WARPS*REG_W | Destination register of each warp's next instruction |
| dst_en | input | NUM_WARPS | Next instruction writes its destination |
| wb_valid | input | 1 | Writeback strobe |
| wb_warp | input | WID_W | Warp of the returning write |
| wb_reg | input | REG_W | Register of the returning write |
| grant_valid | output | 1 | An instruction issues this cycle |
| grant_warp | output | WID_W | Index of the issuing warp |

## Verification
A directed sequence covers several cases in turn. It first drives a single resident warp and checks that the issue spacing is enforced. It then drives a warp that reads a register it has just marked pending, which separates a working scoreboard from one that never sets or never clears its bits. Next it drives a warp that writes a register that is already pending, which shows whether write-after-write holding is present. It also drives a writeback in the same cycle as an issue that marks the same register, which shows which of the two wins. Finally it drives full and sparse resident masks, which expose wrong round-robin start points and wrong wrap-around. A long random phase with dense and sparse masks, random operands and random writebacks is then compared cycle by cycle against a reference model in the bench.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

    // Index width for n items, never less than one bit.
    function automatic int idx_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/wsched_scoreboard.sv
module wsched_scoreboard
    import wsched_pkg::*;
#(
    parameter int NUM_WARPS = 32,
    parameter int NUM_REGS  = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  set_en,
    input  logic [idx_width(NUM_WARPS)-1:0]       set_warp,
    input  logic [idx_width(NUM_REGS)-1:0]        set_reg,
    input  logic                                  clr_en,
    input  logic [idx_width(NUM_WARPS)-1:0]       clr_warp,
    input  logic [idx_width(NUM_REGS)-1:0]        clr_reg,
    output logic [NUM_WARPS-1:0][NUM_REGS-1:0]    pend_o
);

    typedef struct packed {
        logic [NUM_WARPS-1:0][NUM_REGS-1:0] pend;
    } sb_state_t;

    sb_state_t sb_d, sb_q;

    always_comb begin
        sb_d = sb_q;
        if (set_en) begin
            sb_d.pend[set_warp][set_reg] = 1'b1;
        end
        // a returning write is applied after the issue mark, so it wins
        if (clr_en) begin
            sb_d.pend[clr_warp][clr_reg] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sb_q <= '0;
        end else begin
            sb_q <= sb_d;
        end
    end

    assign pend_o = sb_q.pend;

endmodule

// File: rtl/wsched_ready.sv
module wsched_ready
    import wsched_pkg::*;
#(
    parameter int NUM_WARPS = 32,
    parameter int NUM_REGS  = 16
) (
    input  logic [NUM_WARPS-1:0][NUM_REGS-1:0]           pend_i,
    input  logic [NUM_WARPS-1:0]                         valid_i,
    input  logic [NUM_WARPS*idx_width(NUM_REGS)-1:0]     src_a_i,
    input  logic [NUM_WARPS*idx_width(NUM_REGS)-1:0]     src_b_i,
    input  logic [NUM_WARPS*idx_width(NUM_REGS)-1:0]     dst_i,
    input  logic [NUM_WARPS-1:0]                         dst_en_i,
    output logic [NUM_WARPS-1:0]                         elig_o
);

    localparam int REG_W = idx_width(NUM_REGS);

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        logic [REG_W-1:0] ra, rb, rd;
        logic             hz_src, hz_dst;

        assign ra = src_a_i[w*REG_W +: REG_W];
        assign rb = src_b_i[w*REG_W +: REG_W];
        assign rd = dst_i[w*REG_W +: REG_W];

        // read-after-write and write-after-write hazards
        assign hz_src    = pend_i[w][ra] | pend_i[w][rb];
        assign hz_dst    = dst_en_i[w] & pend_i[w][rd];
        assign elig_o[w] = valid_i[w] & ~hz_src & ~hz_dst;
    end

endmodule

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick
    import wsched_pkg::*;
#(
    parameter int NUM_WARPS = 32
) (
    input  logic [NUM_WARPS-1:0]             req_i,
    input  logic [idx_width(NUM_WARPS)-1:0]  last_i,
    output logic                             pick_valid_o,
    output logic [idx_width(NUM_WARPS)-1:0]  pick_idx_o
);

    localparam int WID_W = idx_width(NUM_WARPS);

    always_comb begin
        int cand;
        pick_valid_o = 1'b0;
        pick_idx_o   = '0;
        cand         = 0;
        for (int i = 1; i <= NUM_WARPS; i++) begin
            cand = (int'(last_i) + i) % NUM_WARPS;
            if (!pick_valid_o && req_i[cand]) begin
                pick_valid_o = 1'b1;
                pick_idx_o   = WID_W'(cand);
            end
        end
    end

endmodule

// File: rtl/wsched_top.sv
module wsched_top
    import wsched_pkg::*;
#(
    parameter int NUM_WARPS = 32,
    parameter int NUM_REGS  = 16,
    parameter int ISSUE_GAP = 4
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [NUM_WARPS-1:0]                      warp_valid,
    input  logic [NUM_WARPS*idx_width(NUM_REGS)-1:0]  src_a_idx,
    input  logic [NUM_WARPS*idx_width(NUM_REGS)-1:0]  src_b_idx,
    input  logic [NUM_WARPS*idx_width(NUM_REGS)-1:0]  dst_idx,
    input  logic [NUM_WARPS-1:0]                      dst_en,
    input  logic                                      wb_valid,
    input  logic [idx_width(NUM_WARPS)-1:0]           wb_warp,
    input  logic [idx_width(NUM_REGS)-1:0]            wb_reg,
    output logic                                      grant_valid,
    output logic [idx_width(NUM_WARPS)-1:0]           grant_warp
);

    localparam int WID_W = idx_width(NUM_WARPS);
    localparam int REG_W = idx_width(NUM_REGS);
    localparam int GAP_W = idx_width(ISSUE_GAP + 1);

    typedef struct packed {
        logic             gv;
        logic [WID_W-1:0] gw;
        logic [WID_W-1:0] last;
        logic [GAP_W-1:0] cnt;
    } sch_state_t;

    sch_state_t st_d, st_q;

    logic [NUM_WARPS-1:0][NUM_REGS-1:0] pend;
    logic [NUM_WARPS-1:0]               elig;
    logic                               pick_valid;
    logic [WID_W-1:0]                   pick_idx;
    logic                               issue;
    logic [REG_W-1:0]                   sel_a, sel_b, sel_d;
    logic                               sel_de;
    logic                               wb_hits_sel;

    wsched_scoreboard #(
        .NUM_WARPS (NUM_WARPS),
        .NUM_REGS  (NUM_REGS)
    ) u_sb (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (issue & sel_de),
        .set_warp (pick_idx),
        .set_reg  (sel_d),
        .clr_en   (wb_valid),
        .clr_warp (wb_warp),
        .clr_reg  (wb_reg),
        .pend_o   (pend)
    );

    wsched_ready #(
        .NUM_WARPS (NUM_WARPS),
        .NUM_REGS  (NUM_REGS)
    ) u_ready (
        .pend_i   (pend),
        .valid_i  (warp_valid),
        .src_a_i  (src_a_idx),
        .src_b_i  (src_b_idx),
        .dst_i    (dst_idx),
        .dst_en_i (dst_en),
        .elig_o   (elig)
    );

    wsched_rr_pick #(
        .NUM_WARPS (NUM_WARPS)
    ) u_pick (
        .req_i        (elig),
        .last_i       (st_q.last),
        .pick_valid_o (pick_valid),
        .pick_idx_o   (pick_idx)
    );

    // operands of the chosen warp
    always_comb begin
        sel_a       = src_a_idx[pick_idx*REG_W +: REG_W];
        sel_b       = src_b_idx[pick_idx*REG_W +: REG_W];
        sel_d       = dst_idx[pick_idx*REG_W +: REG_W];
        sel_de      = dst_en[pick_idx];
        wb_hits_sel = wb_valid && (wb_warp == pick_idx) && (wb_reg == sel_d);
    end

    assign issue = pick_valid && (st_q.cnt == '0);

    always_comb begin
        st_d    = st_q;
        st_d.gv = issue;
        if (issue) begin
            st_d.gw   = pick_idx;
            st_d.last = pick_idx;
            st_d.cnt  = GAP_W'(ISSUE_GAP - 1);
        end else if (st_q.cnt != '0) begin
            st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.gv   <= 1'b0;
            st_q.gw   <= '0;
            st_q.last <= WID_W'(NUM_WARPS - 1);
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_valid = st_q.gv;
    assign grant_warp  = st_q.gw;

    AST_PICK_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> warp_valid[pick_idx]); // R2

    AST_SRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> (!pend[pick_idx][sel_a] && !pend[pick_idx][sel_b])); // R3

    AST_DST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_valid && sel_de) |-> !pend[pick_idx][sel_d]); // R4

    AST_DST_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && sel_de && !wb_hits_sel) |=> pend[$past(pick_idx)][$past(sel_d)]); // R5

    AST_WB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !pend[$past(wb_warp)][$past(wb_reg)]); // R6

    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |=> !grant_valid); // R8

    if (ISSUE_GAP > 1) begin : g_gap_chk
        AST_ISSUE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            grant_valid |=> !grant_valid); // R9
    end

endmodule

// File: tb/tb_wsched_top.sv
`timescale 1ns/1ps
module tb_wsched_top;

    localparam int NW    = 32;
    localparam int NR    = 16;
    localparam int GAP   = 4;
    localparam int WID_W = 5;
    localparam int REG_W = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NW-1:0]         warp_valid = '0;
    logic [NW*REG_W-1:0]   src_a_idx = '0;
    logic [NW*REG_W-1:0]   src_b_idx = '0;
    logic [NW*REG_W-1:0]   dst_idx = '0;
    logic [NW-1:0]         dst_en = '0;
    logic                  wb_valid = 1'b0;
    logic [WID_W-1:0]      wb_warp = '0;
    logic [REG_W-1:0]      wb_reg = '0;
    logic                  grant_valid;
    logic [WID_W-1:0]      grant_warp;

    wsched_top #(.NUM_WARPS(NW), .NUM_REGS(NR), .ISSUE_GAP(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .dst_idx(dst_idx),
        .dst_en(dst_en), .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
        .grant_valid(grant_valid), .grant_warp(grant_warp)
    );

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // stimulus arrays and reference model
    int va[NW], vb[NW], vd[NW];
    bit de[NW], vv[NW];
    bit m_pend[NW][NR];
    int m_last, m_cnt;

    task automatic check(input bit ok, input string tag, input int av, input int aw,
                         input int ev, input int ew);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: grant_valid=%0d grant_warp=%0d expected valid=%0d warp=%0d",
                     tag, av, aw, ev, ew);
        end
    endtask

    task automatic model_reset();
        for (int w = 0; w < NW; w++)
            for (int r = 0; r < NR; r++) m_pend[w][r] = 0;
        m_last = NW - 1;
        m_cnt  = 0;
    endtask

    task automatic set_all(input int a, input int b, input int d, input bit e);
        for (int w = 0; w < NW; w++) begin
            va[w] = a; vb[w] = b; vd[w] = d; de[w] = e; vv[w] = 0;
        end
    endtask

    // one clock: drive, predict, advance, compare with model
    task automatic cycle(input string tag);
        bit ev; int ew; int c; bit ok;
        for (int w = 0; w < NW; w++) begin
            warp_valid[w] = vv[w];
            src_a_idx[w*REG_W +: REG_W] = REG_W'(va[w]);
            src_b_idx[w*REG_W +: REG_W] = REG_W'(vb[w]);
            dst_idx[w*REG_W +: REG_W]   = REG_W'(vd[w]);
            dst_en[w] = de[w];
        end
        ev = 0; ew = 0;
        for (int i = 1; i <= NW; i++) begin
            c = (m_last + i) % NW;
            if (!ev && vv[c] && !m_pend[c][va[c]] && !m_pend[c][vb[c]]
                && !(de[c] && m_pend[c][vd[c]])) begin
                ev = 1; ew = c;
            end
        end
        if (m_cnt != 0) ev = 0;
        if (ev) begin
            m_last = ew;
            if (de[ew]) m_pend[ew][vd[ew]] = 1;
            m_cnt = GAP - 1;
        end else if (m_cnt > 0) begin
            m_cnt--;
        end
        if (wb_valid) m_pend[wb_warp][wb_reg] = 0;
        @(negedge clk);
        ok = (grant_valid == ev) && (!ev || grant_warp == WID_W'(ew));
        check(ok, tag, int'(grant_valid), int'(grant_warp), int'(ev), ew);
    endtask

    task automatic hand(input bit v, input int w, input string tag);
        check((grant_valid == v) && (!v || grant_warp == WID_W'(w)), tag,
              int'(grant_valid), int'(grant_warp), int'(v), w);
    endtask

    task automatic gap_wait();
        for (int i = 0; i < GAP - 1; i++) begin
            cycle("R9 spacing");
            hand(0, 0, "R9 spacing");
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        set_all(10, 11, 12, 0);
        model_reset();
        repeat (3) @(negedge clk);
        hand(0, 0, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        hand(0, 0, "R1 after reset");

        // nothing resident
        for (int w = 0; w < NW; w++) vv[w] = 0;
        cycle("R2 R8 none resident");
        hand(0, 0, "R2 none resident");

        // warp 6 issues, writes r4
        vv[6] = 1; va[6] = 1; vb[6] = 2; vd[6] = 4; de[6] = 1;
        cycle("R7 single");
        hand(1, 6, "R7 single warp");
        vv[6] = 0;
        vv[8] = 1; va[8] = 1; vb[8] = 2; vd[8] = 13; de[8] = 0;
        gap_wait();
        cycle("R9 after gap");
        hand(1, 8, "R9 grant after gap");

        // warp 6 reads r4, pending from its issue
        vv[8] = 0;
        vv[6] = 1; va[6] = 4; vb[6] = 2; de[6] = 0;
        gap_wait();
        cycle("R5 held"); hand(0, 0, "R5 R3 source pending");
        cycle("R3 held"); hand(0, 0, "R3 source pending");
        wb_valid = 1; wb_warp = 6; wb_reg = 4;
        cycle("R6 wb cycle"); hand(0, 0, "R6 wb not bypassed");
        wb_valid = 0;
        cycle("R6 released"); hand(1, 6, "R6 cleared by writeback");

        // write-after-write on warp 9
        vv[6] = 0;
        vv[9] = 1; va[9] = 1; vb[9] = 2; vd[9] = 5; de[9] = 1;
        gap_wait();
        cycle("R4 first"); hand(1, 9, "R4 first write");
        gap_wait();
        cycle("R4 held"); hand(0, 0, "R4 dst pending");
        cycle("R4 held"); hand(0, 0, "R4 dst pending");
        wb_valid = 1; wb_warp = 9; wb_reg = 5;
        cycle("R4 wb"); hand(0, 0, "R4 wb cycle");
        wb_valid = 0;
        cycle("R4 released"); hand(1, 9, "R4 released");

        // writeback coincident with an issue marking the same register
        vv[9] = 0;
        vv[7] = 1; va[7] = 1; vb[7] = 2; vd[7] = 9; de[7] = 1;
        gap_wait();
        wb_valid = 1; wb_warp = 7; wb_reg = 9;
        cycle("R6 coincide"); hand(1, 7, "R6 coincident issue");
        wb_valid = 0;
        va[7] = 9; de[7] = 0;
        gap_wait();
        cycle("R6 clear wins"); hand(1, 7, "R6 clear wins over mark");

        // round robin, all resident
        set_all(10, 11, 12, 0);
        for (int w = 0; w < NW; w++) vv[w] = 1;
        for (int k = 0; k < 3; k++) begin
            gap_wait();
            cycle("R7 rr");
            hand(1, 8 + k, "R7 rotate full mask");
        end
        for (int w = 0; w < NW; w++) vv[w] = 0;
        vv[2] = 1; vv[30] = 1;
        gap_wait(); cycle("R7 sparse"); hand(1, 30, "R7 sparse skip");
        gap_wait(); cycle("R7 wrap");   hand(1, 2,  "R7 wrap around");
        gap_wait(); cycle("R7 wrap");   hand(1, 30, "R7 alternate");

        // random phase against the model
        for (int t = 0; t < 4000; t++) begin
            bit dense;
            dense = ($urandom % 4) != 0;
            for (int w = 0; w < NW; w++) begin
                vv[w] = (t % 61 == 0) ? 1'b0 : (dense ? (($urandom % 4) != 0) : (($urandom % 8) == 0));
                va[w] = $urandom % NR;
                vb[w] = $urandom % NR;
                vd[w] = $urandom % NR;
                de[w] = ($urandom % 4) != 0;
            end
            wb_valid = ($urandom % 8) != 0;
            wb_warp  = WID_W'($urandom % NW);
            wb_reg   = REG_W'($urandom % NR);
            cycle(m_cnt != 0 ? "R9 random" : "R7 R8 R10 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule